// File: doc/BRIEF.md
# Acquisition Scaler and Threshold Monitor

This block takes 8-bit converter samples, each tagged with the channel it came from, and handles them in one of two modes. A single mode bit selects the mode. When the mode bit is high the block is in acquisition mode. Each valid sample goes through a scaling stage picked by a two-bit function code, and the result is registered onto an 8-bit bus that feeds a parallel DAC. At the same time, the channel that supplied the sample is registered and decoded onto a single seven-segment digit.

When the mode bit is low the block is in monitor mode. It walks the channels in order, from 0 up to 7 and then back to 0, and sends a one-cycle request to the conversion sequencer for the next channel after every compare. Each sample is compared against an 8-bit threshold input. The first sample that is strictly above the threshold sets a sticky alarm and latches that sample's channel tag. While the alarm is set, the scan stops advancing. The alarm is cleared by a clear pulse or by any change of the mode bit.

Top module: `acq_scale_monitor`

## Requirements
- R1: After reset, `dac_data` is 0, `seg` shows digit 0 (7'h3F), `alarm` and `alarm_chan` are 0, `req_chan` is 0 and `chan_req` is 0.
- R2: In acquisition mode (`gate`=1), a valid sample updates `dac_data` one clock later. With `fn_sel`=2'b00 or 2'b11 the output equals the input.
- R3: With `fn_sel`=2'b01, the output is twice the input, saturating at 8'hFF when input bit 7 is set.
- R4: With `fn_sel`=2'b10, the output is the input shifted right by one, with the low bit dropped.
- R5: In acquisition mode, a valid sample registers its `smp_chan`, and `seg` shows that digit one clock later. The encoding is `seg`={g,f,e,d,c,b,a}, active high: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07.
- R6: In monitor mode (`gate`=0), `dac_data` holds its value whatever samples arrive.
- R7: In monitor mode with no alarm, each valid sample produces a one-cycle `chan_req` pulse one clock later. It also advances `req_chan` by one, going from 7 back to 0.
- R8: In monitor mode, a valid sample strictly greater than `threshold` sets `alarm` one clock later and latches its `smp_chan` on `alarm_chan`. A sample equal to the threshold does not trip the alarm.
- R9: Once set, `alarm` stays high, and no further `chan_req` is issued, until `alarm_clr` is pulsed or `gate` changes. Either event clears it one clock later and takes priority over a trip in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate | input | 1 | 1 = acquisition mode, 0 = monitor mode |
| fn_sel | input | 2 | Scaling function: 00 pass, 01 double, 10 halve, 11 pass |
| smp_valid | input | 1 | Sample strobe from the sequencer |
| smp_data | input | 8 | Sample value |
| smp_chan | input | 3 | Channel tag of the sample |
| threshold | input | 8 | Alarm threshold |
| alarm_clr | input | 1 | Pulse to clear the sticky alarm |
| dac_data | output | 8 | Scaled sample toward the DAC |
| seg | output | 7 | Seven-segment pattern {g..a}, active high |
| chan_req | output | 1 | Next-channel request pulse (monitor mode) |
| req_chan | output | 3 | Channel being requested in the scan |
| alarm | output | 1 | Sticky over-threshold alarm |
| alarm_chan | output | 3 | Channel that tripped the alarm |

## Verification
The bench targets the boundaries of the doubling path:
- An input of 8'h7F must give 8'hFE.
- Inputs with bit 7 set must give 8'hFF. A design that wraps would show a small value instead.

It also drives halving of 8'h01, which must give 0, and code 2'b11, which a careless decoder could send down a scaling path.

In monitor mode the bench checks three things:
- A sample equal to the threshold must not trip the alarm, which catches a `>=` compare.
- The scan must wrap from 7 to 0.
- Once the alarm is set, it must hold and stop the scan. A design that dropped the alarm or kept requesting channels would fail.

Clearing is checked both by pulse and by a mode change.

// File: rtl/acq_scale_monitor.sv
module acq_scale_monitor #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate,
  input  logic [1:0]    fn_sel,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic [2:0]    smp_chan,
  input  logic [DW-1:0] threshold,
  input  logic          alarm_clr,
  output logic [DW-1:0] dac_data,
  output logic [6:0]    seg,
  output logic          chan_req,
  output logic [2:0]    req_chan,
  output logic          alarm,
  output logic [2:0]    alarm_chan
);
  localparam logic [DW-1:0] FULL = {DW{1'b1}};

  logic          gate_q;
  logic [2:0]    disp_chan;
  logic [DW-1:0] scaled;
  logic          clear_now;
  logic          mon_hit;

  always_comb begin
    unique case (fn_sel)
      2'b01:   scaled = smp_data[DW-1] ? FULL : {smp_data[DW-2:0], 1'b0};
      2'b10:   scaled = {1'b0, smp_data[DW-1:1]};
      default: scaled = smp_data;
    endcase
  end

  assign clear_now = alarm_clr || (gate != gate_q);
  assign mon_hit   = !gate && smp_valid && !alarm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_data  <= '0;
      disp_chan <= '0;
    end else if (gate && smp_valid) begin
      dac_data  <= scaled;
      disp_chan <= smp_chan;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q     <= 1'b0;
      alarm      <= 1'b0;
      alarm_chan <= '0;
      req_chan   <= '0;
      chan_req   <= 1'b0;
    end else begin
      gate_q   <= gate;
      chan_req <= 1'b0;
      if (clear_now) begin
        alarm <= 1'b0;
      end else if (mon_hit) begin
        chan_req <= 1'b1;
        req_chan <= req_chan + 3'd1;
        if (smp_data > threshold) begin
          alarm      <= 1'b1;
          alarm_chan <= smp_chan;
        end
      end
    end
  end

  always_comb begin
    unique case (disp_chan)
      3'd0: seg = 7'h3F;
      3'd1: seg = 7'h06;
      3'd2: seg = 7'h5B;
      3'd3: seg = 7'h4F;
      3'd4: seg = 7'h66;
      3'd5: seg = 7'h6D;
      3'd6: seg = 7'h7D;
      default: seg = 7'h07;
    endcase
  end
endmodule

module acq_scale_monitor_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gate,
  input logic [1:0]    fn_sel,
  input logic          smp_valid,
  input logic [DW-1:0] smp_data,
  input logic          alarm_clr,
  input logic [DW-1:0] dac_data,
  input logic [6:0]    seg,
  input logic          chan_req,
  input logic          alarm
);
  assert_double_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && smp_valid && fn_sel == 2'b01 && smp_data[DW-1]) |=> dac_data == {DW{1'b1}});

  assert_seg_lit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seg != 7'h00);

  assert_dac_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> $stable(dac_data));

  assert_req_after_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chan_req |-> ($past(smp_valid) && !$past(gate)));

  assert_alarm_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> (!$past(gate) && $past(smp_valid)));

  assert_alarm_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !alarm_clr && $stable(gate)) |=> alarm);
endmodule

bind acq_scale_monitor acq_scale_monitor_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate(gate), .fn_sel(fn_sel),
  .smp_valid(smp_valid), .smp_data(smp_data), .alarm_clr(alarm_clr),
  .dac_data(dac_data), .seg(seg), .chan_req(chan_req), .alarm(alarm)
);

// File: tb/acq_scale_monitor_test.sv
module acq_scale_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {fn_sel[2], data[8], chan[3], exp_dac[8], exp_seg[7]}
  localparam logic [27:0] VEC [NVEC] = '{
    {2'b00, 8'h5A, 3'd3, 8'h5A, 7'h4F},
    {2'b01, 8'h30, 3'd1, 8'h60, 7'h06},
    {2'b01, 8'h80, 3'd7, 8'hFF, 7'h07},
    {2'b01, 8'hC3, 3'd2, 8'hFF, 7'h5B},
    {2'b10, 8'hFF, 3'd4, 8'h7F, 7'h66},
    {2'b10, 8'h01, 3'd5, 8'h00, 7'h6D},
    {2'b11, 8'hA5, 3'd6, 8'hA5, 7'h7D},
    {2'b01, 8'h7F, 3'd0, 8'hFE, 7'h3F}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gate = 1'b1;
  logic [1:0] fn_sel = 2'b00;
  logic       smp_valid = 1'b0;
  logic [7:0] smp_data = 8'h00;
  logic [2:0] smp_chan = 3'd0;
  logic [7:0] threshold = 8'h80;
  logic       alarm_clr = 1'b0;
  logic [7:0] dac_data;
  logic [6:0] seg;
  logic       chan_req;
  logic [2:0] req_chan;
  logic       alarm;
  logic [2:0] alarm_chan;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acq_scale_monitor uut (
    .clk(clk), .rst_n(rst_n), .gate(gate), .fn_sel(fn_sel),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan),
    .threshold(threshold), .alarm_clr(alarm_clr), .dac_data(dac_data),
    .seg(seg), .chan_req(chan_req), .req_chan(req_chan), .alarm(alarm),
    .alarm_chan(alarm_chan)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sample(input logic [7:0] d, input logic [2:0] c);
    smp_data  = d;
    smp_chan  = c;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 dac", dac_data, 0);
    check("R1 seg", seg, 7'h3F);
    check("R1 alarm", alarm, 0);
    check("R1 alarm_chan", alarm_chan, 0);
    check("R1 req_chan", req_chan, 0);
    check("R1 chan_req", chan_req, 0);

    for (int i = 0; i < NVEC; i++) begin
      fn_sel = VEC[i][27:26];
      sample(VEC[i][25:18], VEC[i][17:15]);
      check("R2/R3/R4 dac", dac_data, VEC[i][14:7]);
      check("R5 seg", seg, VEC[i][6:0]);
    end

    gate = 1'b0;
    threshold = 8'h80;
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      sample((k == 0) ? 8'h80 : 8'h10 + k[7:0], k[2:0]);
      check("R7 chan_req pulse", chan_req, 1);
      check("R7 req_chan", req_chan, (k + 1) % 8);
      check("R8 no trip at or below", alarm, 0);
      check("R6 dac hold", dac_data, 8'hFE);
      @(negedge clk);
      check("R7 pulse one cycle", chan_req, 0);
    end

    sample(8'h81, 3'd3);
    check("R8 trip", alarm, 1);
    check("R8 alarm_chan", alarm_chan, 3);
    check("R6 dac hold on trip", dac_data, 8'hFE);
    @(negedge clk);
    sample(8'h00, 3'd5);
    check("R9 sticky", alarm, 1);
    check("R9 scan halted req", chan_req, 0);
    check("R9 scan halted chan", req_chan, 1);
    check("R9 alarm_chan held", alarm_chan, 3);

    alarm_clr = 1'b1;
    sample(8'hF0, 3'd6);
    alarm_clr = 1'b0;
    check("R9 clear pulse wins", alarm, 0);
    check("R9 no request on clear", chan_req, 0);

    sample(8'hF0, 3'd6);
    check("R8 retrip", alarm, 1);
    check("R8 retrip chan", alarm_chan, 6);
    gate = 1'b1;
    @(negedge clk);
    check("R9 gate change clears", alarm, 0);

    fn_sel = 2'b11;
    sample(8'h3C, 3'd2);
    check("R2 code 11 passes", dac_data, 8'h3C);
    check("R5 seg 2", seg, 7'h5B);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule